// File: doc/BRIEF.md
# Self-Triggered Projection Hit Readout

This block watches the binary hit flags of a small pixel matrix and reads out, with no external trigger, a reduced picture of each event. A hit on any enabled pixel, or a pulse from a neighbouring block on the trigger input, arms a programmable delay. When the delay runs out, the block latches two projections of the masked hit pattern: one bit per column (set if any pixel in that column is hit) and one bit per row (set if any pixel in that row is hit).

Both projections are then sent out at the same time on two serial lines, one per axis. Only set bits are sent. Each one goes out as a start bit followed by its address, and an all-ones marker closes the event. A serially loaded disable mask removes noisy pixels and sets the active area. A clear sequence empties the mask, and a busy output shows while the mask is changing. A delayed copy of the local trigger leaves the block to drive the next block in a chain.

Top module: `hit_proj_readout`

## Requirements
- R1: In the idle state, with the mask not busy, a hit on any enabled pixel starts a capture. The projections are latched D+1 clock edges after the edge that first sees the hit, where D is the value on `trig_dly` at that edge (0 to 2^DLYW-1).
- R2: Pixel (row r, column c) is bit r*COLS+c of `hit` and of the mask. A mask bit of 1 disables that pixel. A disabled pixel starts no capture and is left out of both projections.
- R3: `trig_out` goes high for exactly one cycle, in the cycle after the latching edge, and only for a capture in which a local enabled hit was present at the starting edge.
- R4: A high `trig_in` in the idle state, with the mask not busy, starts a capture with the same delay and latching as a local hit, but gives no `trig_out` pulse.
- R5: `sdo_x` starts sending in the cycle after the edge that follows the latch, one bit per cycle and with no gaps. For each set column bit, in ascending column order, it sends a 1 and then the column number in XAW = clog2(COLS+1) bits, MSB first. It then sends XAW+1 ones and returns low.
- R6: `sdo_y` uses the same timing and format for the row bits, with YAW = clog2(ROWS+1) address bits.
- R7: From the starting edge until both lines have returned low, new hits and `trig_in` are ignored. The block goes back to idle at the first edge at which both lines have finished.
- R8: Each edge with `mask_clk_en` high (and no clear running) shifts `mask_din` into mask bit 0 and moves bit i to bit i+1.
- R9: A `mask_clr` pulse while no clear is running shifts zeros into the mask on the next ROWS*COLS edges. `mask_busy` is high while the clear runs or while `mask_clk_en` is high. No capture starts while `mask_busy` is high.
- R10: A synchronous active-high `rst` enables every pixel, stops any capture and sets `sdo_x`, `sdo_y`, `trig_out` and `mask_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | ROWS*COLS | Binary hit flags, bit r*COLS+c |
| trig_in | input | 1 | Trigger from a neighbouring block |
| trig_dly | input | DLYW | Trigger delay in clock cycles |
| trig_out | output | 1 | Delayed local trigger pulse |
| mask_clk_en | input | 1 | Shift enable for the disable mask |
| mask_din | input | 1 | Serial disable bit |
| mask_clr | input | 1 | Start a full mask clear |
| mask_busy | output | 1 | Mask shift or clear in progress |
| sdo_x | output | 1 | Serial column projection stream |
| sdo_y | output | 1 | Serial row projection stream |

## Verification
A single pixel gives one column word and one row word, so it tests address bit order and trigger latency. A scattered pattern with several pixels in the same row or column shows whether the projections merge hits correctly and send them in ascending order. Adding a masked pixel to a pattern separates the projection logic from the disable mask, and a trigger-in capture with no hits gives frames made of end markers only. New hits during a frame, and hits held across a mask clear, show that stimulus arriving while busy is ignored, not queued.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } cap_state_t;
endpackage

// File: rtl/hpr_mask_chain.sv
module hpr_mask_chain #(
   parameter int NPIX = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            shift_en,
   input  logic            din,
   input  logic            clr_start,
   output logic [NPIX-1:0] dis,
   output logic            busy
);
   localparam int CW = $clog2(NPIX + 1);

   logic [CW-1:0] clr_cnt;

   generate
      if (NPIX < 2) begin : g_bad_npix
         $error("hpr_mask_chain: NPIX must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         dis     <= '0;
         clr_cnt <= '0;
      end else if (clr_cnt != '0) begin
         dis     <= {dis[NPIX-2:0], 1'b0};
         clr_cnt <= clr_cnt - 1'b1;
      end else if (clr_start) begin
         clr_cnt <= CW'(NPIX);
      end else if (shift_en) begin
         dis <= {dis[NPIX-2:0], din};
      end
   end

   assign busy = (clr_cnt != '0) | shift_en;
endmodule

// File: rtl/hpr_project.sv
module hpr_project #(
   parameter int ROWS = 4,
   parameter int COLS = 8
) (
   input  logic [ROWS*COLS-1:0] pix,
   output logic [COLS-1:0]      colp,
   output logic [ROWS-1:0]      rowp
);
   genvar r;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         assign rowp[r] = |pix[r*COLS +: COLS];
      end
   endgenerate

   always_comb begin
      colp = '0;
      for (int rr = 0; rr < ROWS; rr++) begin
         colp = colp | pix[rr*COLS +: COLS];
      end
   end
endmodule

// File: rtl/hpr_serializer.sv
module hpr_serializer #(
   parameter int N  = 8,
   parameter int AW = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [N-1:0] proj_in,
   output logic         sdo,
   output logic         busy
);
   localparam int W  = AW + 1;
   localparam int BW = $clog2(W + 1);

   logic [N-1:0]  pend;
   logic [W-1:0]  shreg;
   logic [BW-1:0] bcnt;
   logic          last;
   logic [AW-1:0] ffs;
   logic          any;
   logic [W-1:0]  word;

   generate
      if ((1 << AW) <= N) begin : g_bad_aw
         $error("hpr_serializer: AW too small to keep the end marker unique");
      end
   endgenerate

   always_comb begin
      ffs = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            ffs = AW'(i);
            any = 1'b1;
         end
      end
      word = {1'b1, ffs};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend  <= '0;
         shreg <= '0;
         bcnt  <= '0;
         last  <= 1'b0;
         busy  <= 1'b0;
         sdo   <= 1'b0;
      end else if (load) begin
         pend  <= proj_in;
         bcnt  <= '0;
         last  <= 1'b0;
         busy  <= 1'b1;
         sdo   <= 1'b0;
      end else if (busy) begin
         if (bcnt != '0) begin
            sdo   <= shreg[W-1];
            shreg <= shreg << 1;
            bcnt  <= bcnt - 1'b1;
         end else if (any) begin
            sdo   <= word[W-1];
            shreg <= word << 1;
            pend  <= pend & ~(N'(1) << ffs);
            bcnt  <= BW'(W - 1);
         end else if (!last) begin
            sdo   <= 1'b1;
            shreg <= '1;
            bcnt  <= BW'(W - 1);
            last  <= 1'b1;
         end else begin
            sdo   <= 1'b0;
            busy  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hit_proj_readout.sv
module hit_proj_readout #(
   parameter int ROWS = 4,
   parameter int COLS = 8,
   parameter int DLYW = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ROWS*COLS-1:0] hit,
   input  logic                 trig_in,
   input  logic [DLYW-1:0]      trig_dly,
   output logic                 trig_out,
   input  logic                 mask_clk_en,
   input  logic                 mask_din,
   input  logic                 mask_clr,
   output logic                 mask_busy,
   output logic                 sdo_x,
   output logic                 sdo_y
);
   import hpr_pkg::*;

   localparam int NPIX = ROWS * COLS;
   localparam int XAW  = $clog2(COLS + 1);
   localparam int YAW  = $clog2(ROWS + 1);

   generate
      if (ROWS < 1 || COLS < 1 || NPIX < 2) begin : g_bad_dims
         $error("hit_proj_readout: matrix needs at least two pixels");
      end
      if (DLYW < 1) begin : g_bad_dly
         $error("hit_proj_readout: DLYW must be at least 1");
      end
   endgenerate

   logic [NPIX-1:0] dis;
   logic [NPIX-1:0] masked;
   logic [COLS-1:0] colp;
   logic [ROWS-1:0] rowp;
   logic            local_hit;
   logic            latch;
   logic            x_busy, y_busy;
   logic            loc_src;
   logic [DLYW-1:0] cnt;
   cap_state_t      st;

   hpr_mask_chain #(.NPIX(NPIX)) u_mask (
      .clk      (clk),
      .rst      (rst),
      .shift_en (mask_clk_en),
      .din      (mask_din),
      .clr_start(mask_clr),
      .dis      (dis),
      .busy     (mask_busy)
   );

   assign masked    = hit & ~dis;
   assign local_hit = |masked;

   hpr_project #(.ROWS(ROWS), .COLS(COLS)) u_proj (
      .pix (masked),
      .colp(colp),
      .rowp(rowp)
   );

   assign latch = (st == ST_WAIT) && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         loc_src  <= 1'b0;
         trig_out <= 1'b0;
      end else begin
         trig_out <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (!mask_busy && (local_hit || trig_in)) begin
                  st      <= ST_WAIT;
                  cnt     <= trig_dly;
                  loc_src <= local_hit;
               end
            end
            ST_WAIT: begin
               if (cnt == '0) begin
                  st       <= ST_SEND;
                  trig_out <= loc_src;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_SEND: begin
               if (!x_busy && !y_busy) begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   hpr_serializer #(.N(COLS), .AW(XAW)) u_ser_x (
      .clk    (clk),
      .rst    (rst),
      .load   (latch),
      .proj_in(colp),
      .sdo    (sdo_x),
      .busy   (x_busy)
   );

   hpr_serializer #(.N(ROWS), .AW(YAW)) u_ser_y (
      .clk    (clk),
      .rst    (rst),
      .load   (latch),
      .proj_in(rowp),
      .sdo    (sdo_y),
      .busy   (y_busy)
   );
endmodule

// File: rtl/hpr_readout_chk.sv
module hpr_readout_chk
   import hpr_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       trig_out,
   input logic       sdo_x,
   input logic       sdo_y,
   input logic       mask_busy,
   input logic       mask_clr,
   input cap_state_t st,
   input logic       x_busy,
   input logic       y_busy
);
   p_trig_single_r3: assert property (@(posedge clk) disable iff (rst)
      trig_out |=> !trig_out);

   p_trig_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
      trig_out |-> $past(st) == ST_WAIT);

   p_x_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
      !x_busy |-> !sdo_x);

   p_y_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
      !y_busy |-> !sdo_y);

   p_send_holds_r7: assert property (@(posedge clk) disable iff (rst)
      (st == ST_SEND && (x_busy || y_busy)) |=> st == ST_SEND);

   p_no_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && mask_busy) |=> st == ST_IDLE);

   p_clr_sets_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (mask_clr && !mask_busy) |=> mask_busy);

   p_reset_quiet_r10: assert property (@(posedge clk)
      rst |=> (!sdo_x && !sdo_y && !trig_out && st == ST_IDLE));
endmodule

bind hit_proj_readout hpr_readout_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .trig_out (trig_out),
   .sdo_x    (sdo_x),
   .sdo_y    (sdo_y),
   .mask_busy(mask_busy),
   .mask_clr (mask_clr),
   .st       (st),
   .x_busy   (x_busy),
   .y_busy   (y_busy)
);

// File: tb/tb_hit_proj_readout.sv
module tb_hit_proj_readout;
   localparam int CLK_P = 10;
   localparam int ROWS  = 4;
   localparam int COLS  = 8;
   localparam int N     = ROWS * COLS;
   localparam int XAW   = $clog2(COLS + 1);
   localparam int YAW   = $clog2(ROWS + 1);

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] hit = '0;
   logic         trig_in = 1'b0;
   logic [3:0]   trig_dly = '0;
   logic         mask_clk_en = 1'b0;
   logic         mask_din = 1'b0;
   logic         mask_clr = 1'b0;
   logic         trig_out, mask_busy, sdo_x, sdo_y;

   hit_proj_readout #(.ROWS(ROWS), .COLS(COLS), .DLYW(4)) dut (
      .clk(clk), .rst(rst), .hit(hit), .trig_in(trig_in), .trig_dly(trig_dly),
      .trig_out(trig_out), .mask_clk_en(mask_clk_en), .mask_din(mask_din),
      .mask_clr(mask_clr), .mask_busy(mask_busy), .sdo_x(sdo_x), .sdo_y(sdo_y)
   );

   always #(CLK_P/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   int cyc = 0;
   int n_trig = 0;
   int ones_x = 0;
   int ones_y = 0;
   int t_trig = 0;

   // reference model state
   bit [N-1:0] m_dis;
   int m_clr, m_st, m_cnt;
   bit m_loc, m_xa, m_ya, e_x, e_y, e_trig, latch_now, busy_now, lh;
   bit qx[$];
   bit qy[$];
   bit [N-1:0] mk;
   bit [COLS-1:0] cp;
   bit [ROWS-1:0] rp;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_dis = '0; m_clr = 0; m_st = 0; m_cnt = 0; m_loc = 0;
         m_xa = 0; m_ya = 0; e_x = 0; e_y = 0; e_trig = 0;
         qx.delete(); qy.delete();
      end else begin
         busy_now = (m_clr != 0) || mask_clk_en;
         mk = hit & ~m_dis;
         lh = (mk != '0);
         e_trig = 0;
         latch_now = 0;
         if (m_st == 0) begin
            if (!busy_now && (lh || trig_in)) begin
               m_st = 1; m_cnt = int'(trig_dly); m_loc = lh;
            end
         end else if (m_st == 1) begin
            if (m_cnt == 0) begin
               m_st = 2; e_trig = m_loc; latch_now = 1;
               cp = '0; rp = '0;
               for (int i = 0; i < N; i++) if (mk[i]) begin cp[i % COLS] = 1; rp[i / COLS] = 1; end
               qx.delete(); qy.delete();
               for (int c = 0; c < COLS; c++) if (cp[c]) begin
                  qx.push_back(1'b1);
                  for (int b = XAW - 1; b >= 0; b--) qx.push_back(((c >> b) & 1) != 0);
               end
               for (int b = 0; b <= XAW; b++) qx.push_back(1'b1);
               for (int r = 0; r < ROWS; r++) if (rp[r]) begin
                  qy.push_back(1'b1);
                  for (int b = YAW - 1; b >= 0; b--) qy.push_back(((r >> b) & 1) != 0);
               end
               for (int b = 0; b <= YAW; b++) qy.push_back(1'b1);
            end else m_cnt--;
         end else begin
            if (!m_xa && !m_ya) m_st = 0;
         end
         if (latch_now) begin m_xa = 1; e_x = 0; end
         else if (m_xa) begin
            if (qx.size() > 0) e_x = qx.pop_front(); else begin m_xa = 0; e_x = 0; end
         end
         if (latch_now) begin m_ya = 1; e_y = 0; end
         else if (m_ya) begin
            if (qy.size() > 0) e_y = qy.pop_front(); else begin m_ya = 0; e_y = 0; end
         end
         if (m_clr != 0) begin m_dis = m_dis << 1; m_clr--; end
         else if (mask_clr) m_clr = N;
         else if (mask_clk_en) m_dis = {m_dis[N-2:0], mask_din};
      end
   end

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (!rst && !finished) begin
         check(sdo_x == e_x, "R5 sdo_x", int'(sdo_x), int'(e_x));
         check(sdo_y == e_y, "R6 sdo_y", int'(sdo_y), int'(e_y));
         check(trig_out == e_trig, "R3 trig_out", int'(trig_out), int'(e_trig));
         check(mask_busy == ((m_clr != 0) || mask_clk_en), "R9 mask_busy",
               int'(mask_busy), int'((m_clr != 0) || mask_clk_en));
         if (trig_out) begin n_trig++; t_trig = cyc; end
         if (sdo_x) ones_x++;
         if (sdo_y) ones_y++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      int base, t0;
      tick(3);
      // R10: outputs quiet right after reset
      check(!sdo_x && !sdo_y && !trig_out && !mask_busy, "R10 reset",
            int'({sdo_x, sdo_y, trig_out, mask_busy}), 0);
      rst = 1'b0;
      tick(2);

      // R1/R5/R6: single pixel row 2 col 5, delay 0
      ones_x = 0; ones_y = 0; base = n_trig;
      trig_dly = 4'd0; hit[2*COLS+5] = 1'b1; t0 = cyc;
      tick(4); hit = '0;
      tick(60);
      check(n_trig == base + 1, "R1 one capture", n_trig - base, 1);
      check(t_trig - t0 == 2, "R1 latency D=0", t_trig - t0, 2);
      check(ones_x == 8, "R5 ones on x for column 5", ones_x, 8);
      check(ones_y == 6, "R6 ones on y for row 2", ones_y, 6);

      // R1: maximum delay
      base = n_trig; trig_dly = 4'd15; hit[0] = 1'b1; t0 = cyc;
      tick(19); hit = '0;
      tick(60);
      check(t_trig - t0 == 17, "R1 latency D=15", t_trig - t0, 17);

      // R5/R6: scattered pattern with shared rows and columns, delay 5
      trig_dly = 4'd5;
      hit[0*COLS+7] = 1; hit[1*COLS+7] = 1; hit[3*COLS+1] = 1; hit[3*COLS+4] = 1; hit[1*COLS+0] = 1;
      tick(9); hit = '0;
      tick(70);

      // R8/R2: disable pixel (1,3) = bit 11 by shifting the mask
      for (int i = 0; i < N; i++) begin
         mask_clk_en = 1'b1; mask_din = ((N - 1 - i) == 11);
         tick(1);
      end
      mask_clk_en = 1'b0; mask_din = 1'b0;
      base = n_trig; ones_x = 0; trig_dly = 4'd1;
      hit[11] = 1'b1;
      tick(20);
      check(n_trig == base, "R2 disabled pixel no trigger", n_trig - base, 0);
      check(ones_x == 0, "R2 disabled pixel no output", ones_x, 0);
      hit[20] = 1'b1;
      tick(6); hit = '0;
      tick(60);
      check(n_trig == base + 1, "R8 enabled neighbour triggers", n_trig - base, 1);

      // R4: trigger input only, no hits
      base = n_trig; ones_x = 0; ones_y = 0; trig_dly = 4'd2;
      trig_in = 1'b1; tick(1); trig_in = 1'b0;
      tick(40);
      check(n_trig == base, "R4 no trig_out from trig_in", n_trig - base, 0);
      check(ones_x == XAW + 1, "R4 end marker only on x", ones_x, XAW + 1);
      check(ones_y == YAW + 1, "R4 end marker only on y", ones_y, YAW + 1);

      // R7: new hits during a frame are ignored
      base = n_trig; trig_dly = 4'd0;
      hit[3*COLS+6] = 1'b1; tick(4); hit = '0;
      tick(3);
      hit[0*COLS+2] = 1'b1; trig_in = 1'b1; tick(5); hit = '0; trig_in = 1'b0;
      tick(50);
      check(n_trig == base + 1, "R7 hits during frame ignored", n_trig - base, 1);

      // R9: clear mask; held hit waits until busy drops
      base = n_trig;
      mask_clr = 1'b1; tick(1); mask_clr = 1'b0;
      hit[11] = 1'b1;
      tick(20);
      check(n_trig == base, "R9 no capture while clearing", n_trig - base, 0);
      check(mask_busy == 1'b1, "R9 busy during clear", int'(mask_busy), 1);
      tick(16);
      check(n_trig == base + 1, "R9 capture after clear, pixel re-enabled", n_trig - base, 1);
      hit = '0;
      tick(50);

      // R10: reset in the middle of a frame
      hit[5] = 1'b1; tick(6); hit = '0;
      rst = 1'b1; tick(1);
      check(!sdo_x && !sdo_y && !trig_out, "R10 reset mid-frame",
            int'({sdo_x, sdo_y, trig_out}), 0);
      rst = 1'b0; tick(5);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule